// File: doc/BRIEF.md
# Winding Current Chopper Timing Controller

This block sequences the switching of one H-bridge winding under fixed-off-time current regulation. Each cycle begins by driving current into the winding. During an initial blanking window the current comparator is not trusted. Once that window has passed, a trip from the comparator ends the drive phase and starts an off-time of fixed length. That off-time can open with a fast-decay part and finish in slow decay. When it expires, the bridge drives again. The comparator trip arrives asynchronously and passes through a synchronizer inside the block. A zero-current flag arrives already synchronous to the clock.

The blanking length is looked up from the present sine magnitude code and the torque level. The off-time length comes from a three-level select. The decay select picks the fast-decay share of the off-time: none, one blanking period, one eighth, one quarter, one half, or all of it. The choice depends on whether the current set-point is rising or falling. The block works out that direction itself from changes of the sine code. All durations are counted in cycles of the block clock. The output is a two-bit bridge command that the gate-drive logic turns into FET states.

Top module: `winding_chopper`

## Requirements
- R1: While `rstN` is low, `bridgeState` is off (2'b00). On the first clock edge after reset is released with an enabled torque code, the block enters drive (2'b01).
- R2: For the first N clock cycles of a drive phase, where N is the blanking length latched when the phase starts, the trip input is ignored. With the trip held high, the drive phase therefore lasts exactly N+1 cycles. With the trip low, drive continues indefinitely.
- R3: N equals BLANK_UNIT_CYC times a unit count. The sine code groups are 16–31, 8–15, 4–7 and 0–3. The torque column is `torqueCode` 0–7, with 0 meaning 100% and each step 12.5% less. Units for group 16–31: columns 0–1 give 6, columns 2–4 give 5, columns 5–6 give 4, column 7 gives 3. Units for group 8–15: columns 0–2 give 5, columns 3–5 give 4, columns 6–7 give 3. Units for group 4–7: columns 0–2 give 4, others give 3. Units for group 0–3: always 3.
- R4: Three-level selects are encoded 2'b00 low, 2'b01 floating, 2'b10 or 2'b11 high. `toffSel` sets the off-time T to 2, 1 or 3 times TOFF_UNIT_CYC for low, floating and high respectively. After T cycles of decay the bridge drives again.
- R5: Each decay opens with F cycles of fast decay (2'b10), then spends T−F cycles in slow decay (2'b11). The pair {`decHi`,`decLo`} selects F separately for a rising and a falling set-point:
  - low,low: slow in both directions.
  - low,float: slow when rising, quarter when falling.
  - low,high: slow when rising, blank when falling.
  - float,low: blank in both directions.
  - float,float: half in both directions.
  - float,high: quarter in both directions.
  - high,low: slow when rising, half when falling.
  - high,float: slow when rising, eighth when falling.
  - high,high: slow when rising, full when falling.
- R6: The fast part F is computed as follows: eighth is T>>3, quarter is T>>2, half is T>>1, full is T, and blank is the N latched by the drive phase that just ended.
- R7: When `sineCode` changes, the set-point counts as rising if the new code is greater and falling if it is smaller. Between changes the direction holds. The previous code resets to 0.
- R8: When `zeroIn` is high during fast decay, the bridge goes off (2'b00) from the next cycle until the fast part ends. After that comes slow decay, or drive if the off-time has also ended.
- R9: When `torqueCode` is 8 or above (0% torque), the bridge is off from the next cycle, whatever the trip does. When an enabled code returns, drive starts on the next edge.
- R10: The trip passes through two synchronizer flops. Once blanking is over, decay is shown after the third rising clock edge following a rising trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all durations count its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| tripIn | input | 1 | Asynchronous current comparator trip |
| zeroIn | input | 1 | Synchronous flag: winding current near zero |
| sineCode | input | CODE_W | Sine magnitude code of the present step |
| torqueCode | input | TORQUE_W | Torque level, 0 = 100%, 7 = 12.5%, 8 and above = outputs off |
| toffSel | input | 2 | Three-level off-time select |
| decHi | input | 2 | Three-level decay select, upper digit |
| decLo | input | 2 | Three-level decay select, lower digit |
| bridgeState | output | 2 | 00 off, 01 drive, 10 fast decay, 11 slow decay |

## Verification
The cycle at which each result appears is known in advance. The bridge command changes one edge after the condition that causes it, except for the trip, whose effect appears on the third edge after it rises. Phase lengths are therefore fixed: drive lasts N+1 cycles with the trip held, fast decay lasts F cycles, and slow decay lasts T−F cycles. The bench samples on falling edges and measures whole runs of one state, starting from a fresh phase entry. Inputs are changed only when the phase being measured will latch them. Checks after a zero-flag, torque or trip stimulus are made at an exact count of falling edges: one for the zero flag and torque, two and three for the trip.

// File: rtl/chopper_pkg.sv
package chopper_pkg;

  typedef enum logic [1:0] {
    BR_OFF   = 2'b00,
    BR_DRIVE = 2'b01,
    BR_FAST  = 2'b10,
    BR_SLOW  = 2'b11
  } bridge_e;

  typedef enum logic [2:0] {
    FP_NONE,
    FP_BLANK,
    FP_EIGHTH,
    FP_QUARTER,
    FP_HALF,
    FP_FULL
  } fastPart_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBlank;
    logic loadOff;
  } chopStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic blankDone;
    logic tripSeen;
    logic fastLast;
    logic offLast;
    logic noFast;
    logic nearZero;
    logic torqueOff;
  } chopStatus_t;

  // three-level pin: 0 low, 1 floating, 2 high
  function automatic logic [1:0] triLevel(input logic [1:0] pin);
    case (pin)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // blanking length in units, by sine group (3 = top) and torque column
  function automatic logic [2:0] blankUnits(input logic [1:0] grp, input logic [2:0] col);
    logic [2:0] u;
    u = 3'd3;
    case (grp)
      2'd3: begin
        if (col <= 3'd1)      u = 3'd6;
        else if (col <= 3'd4) u = 3'd5;
        else if (col <= 3'd6) u = 3'd4;
        else                  u = 3'd3;
      end
      2'd2: begin
        if (col <= 3'd2)      u = 3'd5;
        else if (col <= 3'd5) u = 3'd4;
        else                  u = 3'd3;
      end
      2'd1: begin
        if (col <= 3'd2) u = 3'd4;
        else             u = 3'd3;
      end
      default: u = 3'd3;
    endcase
    return u;
  endfunction

  // fast-decay share by decay digits and set-point direction
  function automatic fastPart_e decayPart(input logic [1:0] hi, input logic [1:0] lo,
                                          input logic rising);
    fastPart_e p;
    case ({hi, lo})
      4'b0000: p = FP_NONE;
      4'b0001: p = rising ? FP_NONE : FP_QUARTER;
      4'b0010: p = rising ? FP_NONE : FP_BLANK;
      4'b0100: p = FP_BLANK;
      4'b0101: p = FP_HALF;
      4'b0110: p = FP_QUARTER;
      4'b1000: p = rising ? FP_NONE : FP_HALF;
      4'b1001: p = rising ? FP_NONE : FP_EIGHTH;
      4'b1010: p = rising ? FP_NONE : FP_FULL;
      default: p = FP_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/chopper_datapath.sv
module chopper_datapath
  import chopper_pkg::*;
#(
  parameter int BLANK_UNIT_CYC = 3,
  parameter int TOFF_UNIT_CYC  = 100,
  parameter int CODE_W         = 5,
  parameter int TORQUE_W       = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tripIn,
  input  logic                zeroIn,
  input  logic [CODE_W-1:0]   sineCode,
  input  logic [TORQUE_W-1:0] torqueCode,
  input  logic [1:0]          toffSel,
  input  logic [1:0]          decHi,
  input  logic [1:0]          decLo,
  input  chopStrobe_t         strobe,
  output chopStatus_t         status
);

  localparam int TOFF_MAX = 3 * TOFF_UNIT_CYC;
  localparam int CNT_W    = $clog2(TOFF_MAX + 1);
  localparam logic [TORQUE_W-1:0] OFF_CODE = TORQUE_W'(8);

  // trip synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], tripIn};
  end

  // set-point direction from sine code changes
  logic [CODE_W-1:0] prevCode;
  logic              risingQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode <= '0;
      risingQ  <= 1'b0;
    end else if (sineCode != prevCode) begin
      risingQ  <= (sineCode > prevCode);
      prevCode <= sineCode;
    end
  end

  // blanking length
  logic [1:0]       sineGrp;
  logic [2:0]       units;
  logic [CNT_W-1:0] blankNow;
  always_comb begin
    if (sineCode >= CODE_W'(16))     sineGrp = 2'd3;
    else if (sineCode >= CODE_W'(8)) sineGrp = 2'd2;
    else if (sineCode >= CODE_W'(4)) sineGrp = 2'd1;
    else                             sineGrp = 2'd0;
    units    = blankUnits(sineGrp, torqueCode[2:0]);
    blankNow = CNT_W'(int'(units) * BLANK_UNIT_CYC);
  end

  // off-time length
  logic [CNT_W-1:0] toffNow;
  always_comb begin
    case (triLevel(toffSel))
      2'd0:    toffNow = CNT_W'(2 * TOFF_UNIT_CYC);
      2'd1:    toffNow = CNT_W'(TOFF_UNIT_CYC);
      default: toffNow = CNT_W'(3 * TOFF_UNIT_CYC);
    endcase
  end

  // fast-decay length
  logic [CNT_W-1:0] blankHeld;
  fastPart_e        part;
  logic [CNT_W-1:0] fastLen;
  always_comb begin
    part = decayPart(triLevel(decHi), triLevel(decLo), risingQ);
    case (part)
      FP_BLANK:   fastLen = blankHeld;
      FP_EIGHTH:  fastLen = toffNow >> 3;
      FP_QUARTER: fastLen = toffNow >> 2;
      FP_HALF:    fastLen = toffNow >> 1;
      FP_FULL:    fastLen = toffNow;
      default:    fastLen = '0;
    endcase
  end

  // phase counters
  logic [CNT_W-1:0] blankCnt;
  logic [CNT_W-1:0] offCnt;
  logic [CNT_W-1:0] fastCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt  <= '0;
      blankHeld <= '0;
    end else if (strobe.loadBlank) begin
      blankCnt  <= blankNow;
      blankHeld <= blankNow;
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt  <= '0;
      fastCnt <= '0;
    end else if (strobe.loadOff) begin
      offCnt  <= toffNow;
      fastCnt <= fastLen;
    end else begin
      if (offCnt != '0)  offCnt  <= offCnt - 1'b1;
      if (fastCnt != '0) fastCnt <= fastCnt - 1'b1;
    end
  end

  always_comb begin
    status.blankDone = (blankCnt == '0);
    status.tripSeen  = syncQ[SYNC_STAGES-1];
    status.fastLast  = (fastCnt == CNT_W'(1));
    status.offLast   = (offCnt == CNT_W'(1));
    status.noFast    = (fastLen == '0);
    status.nearZero  = zeroIn;
    status.torqueOff = (torqueCode >= OFF_CODE);
  end

endmodule

// File: rtl/chopper_control.sv
module chopper_control
  import chopper_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chopStatus_t status,
  output chopStrobe_t strobe,
  output bridge_e     bridgeNow
);

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DRIVE,
    ST_FAST,
    ST_COAST,
    ST_SLOW
  } chopState_e;

  chopState_e stateQ;
  chopState_e stateD;

  always_comb begin
    stateD           = stateQ;
    strobe.loadBlank = 1'b0;
    strobe.loadOff   = 1'b0;
    if (status.torqueOff) begin
      stateD = ST_OFF;
    end else begin
      case (stateQ)
        ST_OFF: begin
          stateD           = ST_DRIVE;
          strobe.loadBlank = 1'b1;
        end
        ST_DRIVE: begin
          if (status.blankDone && status.tripSeen) begin
            strobe.loadOff = 1'b1;
            stateD         = status.noFast ? ST_SLOW : ST_FAST;
          end
        end
        ST_FAST, ST_COAST: begin
          if (status.offLast) begin
            stateD           = ST_DRIVE;
            strobe.loadBlank = 1'b1;
          end else if (status.fastLast) begin
            stateD = ST_SLOW;
          end else if (stateQ == ST_FAST && status.nearZero) begin
            stateD = ST_COAST;
          end
        end
        ST_SLOW: begin
          if (status.offLast) begin
            stateD           = ST_DRIVE;
            strobe.loadBlank = 1'b1;
          end
        end
        default: stateD = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end

  always_comb begin
    case (stateQ)
      ST_DRIVE: bridgeNow = BR_DRIVE;
      ST_FAST:  bridgeNow = BR_FAST;
      ST_SLOW:  bridgeNow = BR_SLOW;
      default:  bridgeNow = BR_OFF;
    endcase
  end

endmodule

// File: rtl/winding_chopper.sv
module winding_chopper
  import chopper_pkg::*;
#(
  parameter int BLANK_UNIT_CYC = 3,
  parameter int TOFF_UNIT_CYC  = 100,
  parameter int CODE_W         = 5,
  parameter int TORQUE_W       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tripIn,
  input  logic                zeroIn,
  input  logic [CODE_W-1:0]   sineCode,
  input  logic [TORQUE_W-1:0] torqueCode,
  input  logic [1:0]          toffSel,
  input  logic [1:0]          decHi,
  input  logic [1:0]          decLo,
  output logic [1:0]          bridgeState
);

  chopStrobe_t strobe;
  chopStatus_t status;
  bridge_e     bridgeNow;

  chopper_datapath #(
    .BLANK_UNIT_CYC(BLANK_UNIT_CYC),
    .TOFF_UNIT_CYC (TOFF_UNIT_CYC),
    .CODE_W        (CODE_W),
    .TORQUE_W      (TORQUE_W),
    .SYNC_STAGES   (2)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .tripIn    (tripIn),
    .zeroIn    (zeroIn),
    .sineCode  (sineCode),
    .torqueCode(torqueCode),
    .toffSel   (toffSel),
    .decHi     (decHi),
    .decLo     (decLo),
    .strobe    (strobe),
    .status    (status)
  );

  chopper_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .status   (status),
    .strobe   (strobe),
    .bridgeNow(bridgeNow)
  );

  assign bridgeState = bridgeNow;

endmodule

// File: rtl/winding_chopper_checker.sv
module winding_chopper_checker #(
  parameter int BLANK_UNIT_CYC = 3,
  parameter int TOFF_UNIT_CYC  = 100,
  parameter int TORQUE_W       = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [TORQUE_W-1:0] torqueCode,
  input logic [1:0]          bridgeState
);

  localparam int TOFF_MAX  = 3 * TOFF_UNIT_CYC;
  localparam int MIN_BLANK = 3 * BLANK_UNIT_CYC;
  localparam int RUN_W     = $clog2(TOFF_MAX + 4);
  localparam logic [TORQUE_W-1:0] OFF_CODE = TORQUE_W'(8);
  localparam logic [RUN_W-1:0] MIN_RUN  = RUN_W'(MIN_BLANK);
  localparam logic [RUN_W-1:0] MAX_RUN  = RUN_W'(TOFF_MAX + 1);

  logic [RUN_W-1:0] driveRun;
  logic [RUN_W-1:0] decayRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveRun <= '0;
      decayRun <= '0;
    end else begin
      if (bridgeState == 2'b01) begin
        if (driveRun != '1) driveRun <= driveRun + 1'b1;
      end else begin
        driveRun <= '0;
      end
      if (bridgeState != 2'b01 && torqueCode < OFF_CODE) begin
        if (decayRun != '1) decayRun <= decayRun + 1'b1;
      end else begin
        decayRun <= '0;
      end
    end
  end

  // R9: zero torque forces the bridge off
  p_torque_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (torqueCode >= OFF_CODE) |=> (bridgeState == 2'b00));

  // R9: an enabled drive never drops straight to off
  p_drive_not_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeState == 2'b01 && torqueCode < OFF_CODE) |=> (bridgeState != 2'b00));

  // R2: drive holds through the shortest blanking window
  p_blank_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeState == 2'b01 && torqueCode < OFF_CODE && driveRun < MIN_RUN)
      |=> (bridgeState == 2'b01));

  // R5: slow decay is never followed by fast decay
  p_slow_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeState == 2'b11) |=> (bridgeState != 2'b10));

  // R4: a decay never outlasts the longest off-time
  p_decay_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decayRun <= MAX_RUN));

endmodule

bind winding_chopper winding_chopper_checker #(
  .BLANK_UNIT_CYC(BLANK_UNIT_CYC),
  .TOFF_UNIT_CYC (TOFF_UNIT_CYC),
  .TORQUE_W      (TORQUE_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .torqueCode (torqueCode),
  .bridgeState(bridgeState)
);

// File: tb/winding_chopper_bench.sv
`timescale 1ns/1ps
module winding_chopper_bench;

  localparam logic [1:0] S_OFF = 2'b00;
  localparam logic [1:0] S_DRV = 2'b01;
  localparam logic [1:0] S_FST = 2'b10;
  localparam logic [1:0] S_SLW = 2'b11;
  localparam logic [1:0] P_LO  = 2'b00;
  localparam logic [1:0] P_Z   = 2'b01;
  localparam logic [1:0] P_HI  = 2'b10;
  localparam int T_Z = 100;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tripIn = 1'b1;
  logic       zeroIn = 1'b0;
  logic [4:0] sineCode = 5'd31;
  logic [3:0] torqueCode = 4'd0;
  logic [1:0] toffSel = P_Z;
  logic [1:0] decHi = P_LO;
  logic [1:0] decLo = P_LO;
  logic [1:0] bridgeState;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  winding_chopper u_winding_chopper (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .zeroIn(zeroIn),
    .sineCode(sineCode), .torqueCode(torqueCode), .toffSel(toffSel),
    .decHi(decHi), .decLo(decLo), .bridgeState(bridgeState)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitEntry(input logic [1:0] st);
    @(negedge clk);
    while (bridgeState == st) @(negedge clk);
    while (bridgeState != st) @(negedge clk);
  endtask

  task automatic runLen(input logic [1:0] st, output int n);
    n = 0;
    while (bridgeState == st) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset;
    repeat (5) @(negedge clk);
    check(bridgeState == S_OFF, "R1", "off in reset", bridgeState, S_OFF);
    rstN = 1'b1;
    @(negedge clk);
    check(bridgeState == S_DRV, "R1", "drive after reset", bridgeState, S_DRV);
  endtask

  task automatic blankCase(input logic [4:0] code, input logic [3:0] tq, input int expN);
    int n;
    sineCode = code;
    torqueCode = tq;
    waitEntry(S_DRV);
    runLen(S_DRV, n);
    check(n == expN + 1, "R3", $sformatf("drive length code %0d torque %0d", code, tq),
          n, expN + 1);
  endtask

  task automatic testBlank;
    toffSel = P_Z; decHi = P_LO; decLo = P_LO;
    blankCase(5'd31, 4'd0, 18);
    blankCase(5'd12, 4'd0, 15);
    blankCase(5'd5,  4'd0, 12);
    blankCase(5'd2,  4'd0, 9);
    blankCase(5'd20, 4'd3, 15);
    blankCase(5'd20, 4'd7, 9);
    blankCase(5'd10, 4'd6, 9);
    blankCase(5'd31, 4'd5, 12);
    torqueCode = 4'd0;
  endtask

  task automatic toffCase(input logic [1:0] sel, input int expT);
    int n;
    toffSel = sel;
    waitEntry(S_SLW);
    runLen(S_SLW, n);
    check(n == expT, "R4", $sformatf("off-time sel %0d", sel), n, expT);
    check(bridgeState == S_DRV, "R4", "drive after off-time", bridgeState, S_DRV);
  endtask

  task automatic testToff;
    sineCode = 5'd31; decHi = P_LO; decLo = P_LO;
    toffCase(P_LO, 200);
    toffCase(P_Z, 100);
    toffCase(P_HI, 300);
    toffCase(2'b11, 300);
    toffSel = P_Z;
  endtask

  task automatic decayCase(input logic [1:0] hi, input logic [1:0] lo,
                           input int expF, input string req);
    int n;
    decHi = hi;
    decLo = lo;
    waitEntry(S_DRV);
    runLen(S_DRV, n);
    if (expF > 0) begin
      check(bridgeState == S_FST, req, $sformatf("fast first dec %0d%0d", hi, lo),
            bridgeState, S_FST);
      runLen(S_FST, n);
      check(n == expF, req, $sformatf("fast length dec %0d%0d", hi, lo), n, expF);
    end
    if (expF < T_Z) begin
      check(bridgeState == S_SLW, req, $sformatf("slow next dec %0d%0d", hi, lo),
            bridgeState, S_SLW);
      runLen(S_SLW, n);
      check(n == T_Z - expF, req, $sformatf("slow length dec %0d%0d", hi, lo), n, T_Z - expF);
    end
    check(bridgeState == S_DRV, req, "drive after decay", bridgeState, S_DRV);
  endtask

  task automatic testMixed;
    toffSel = P_Z; torqueCode = 4'd0;
    // rising: 10 -> 20, blank 18
    sineCode = 5'd10; @(negedge clk); sineCode = 5'd20;
    decayCase(P_Z,  P_HI, 25, "R5");
    decayCase(P_LO, P_Z,  0,  "R7");
    decayCase(P_Z,  P_LO, 18, "R6");
    decayCase(P_HI, P_HI, 0,  "R7");
    // falling: 20 -> 10, blank 15
    sineCode = 5'd10;
    decayCase(P_HI, P_HI, 100, "R5");
    decayCase(P_HI, P_Z,  12,  "R6");
    decayCase(P_LO, P_HI, 15,  "R6");
    decayCase(P_LO, P_Z,  25,  "R7");
    decayCase(P_Z,  P_Z,  50,  "R5");
    decayCase(P_HI, P_LO, 50,  "R5");
    decayCase(P_LO, P_LO, 0,   "R5");
  endtask

  task automatic testZero;
    int n;
    toffSel = P_Z; sineCode = 5'd10;
    decHi = P_HI; decLo = P_HI;
    waitEntry(S_DRV);
    runLen(S_DRV, n);
    repeat (10) @(negedge clk);
    zeroIn = 1'b1;
    @(negedge clk);
    check(bridgeState == S_OFF, "R8", "off after zero in full fast", bridgeState, S_OFF);
    runLen(S_OFF, n);
    check(n == 89, "R8", "coast length full fast", n, 89);
    check(bridgeState == S_DRV, "R8", "drive after coast", bridgeState, S_DRV);
    zeroIn = 1'b0;
    decHi = P_Z; decLo = P_Z;
    waitEntry(S_DRV);
    runLen(S_DRV, n);
    repeat (10) @(negedge clk);
    zeroIn = 1'b1;
    @(negedge clk);
    zeroIn = 1'b0;
    check(bridgeState == S_OFF, "R8", "off after zero in half fast", bridgeState, S_OFF);
    runLen(S_OFF, n);
    check(n == 39, "R8", "coast length half fast", n, 39);
    runLen(S_SLW, n);
    check(n == 50, "R8", "slow after coast", n, 50);
  endtask

  task automatic testTorque;
    int bad;
    bad = 0;
    @(negedge clk);
    torqueCode = 4'd8;
    @(negedge clk);
    check(bridgeState == S_OFF, "R9", "off one cycle after zero torque", bridgeState, S_OFF);
    for (int i = 0; i < 20; i++) begin
      tripIn = i[1];
      @(negedge clk);
      if (bridgeState != S_OFF) bad++;
    end
    check(bad == 0, "R9", "stays off with trip toggling", bad, 0);
    torqueCode = 4'd12;
    @(negedge clk);
    check(bridgeState == S_OFF, "R9", "off at code 12", bridgeState, S_OFF);
    tripIn = 1'b1;
    torqueCode = 4'd0;
    @(negedge clk);
    check(bridgeState == S_DRV, "R9", "drive on re-enable", bridgeState, S_DRV);
  endtask

  task automatic testTripSync;
    int n;
    sineCode = 5'd31; decHi = P_LO; decLo = P_LO; toffSel = P_Z;
    waitEntry(S_DRV);
    runLen(S_DRV, n);
    tripIn = 1'b0;
    while (bridgeState != S_DRV) @(negedge clk);
    tripIn = 1'b1;
    repeat (3) @(negedge clk);
    tripIn = 1'b0;
    repeat (37) @(negedge clk);
    check(bridgeState == S_DRV, "R2", "trip pulse inside blanking ignored", bridgeState, S_DRV);
    tripIn = 1'b1;
    @(negedge clk);
    check(bridgeState == S_DRV, "R10", "drive one edge after trip", bridgeState, S_DRV);
    @(negedge clk);
    check(bridgeState == S_DRV, "R10", "drive two edges after trip", bridgeState, S_DRV);
    @(negedge clk);
    check(bridgeState == S_SLW, "R10", "decay three edges after trip", bridgeState, S_SLW);
  endtask

  initial begin
    testReset;
    testBlank;
    testToff;
    testMixed;
    testZero;
    testTorque;
    testTripSync;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule